// File: doc/BRIEF.md
# Radial–Azimuthal Track Coincidence Unit

This block serves one cluster of eight neighbouring sub-sectors in a muon trigger pipeline. On every clock it accepts one packed 19-bit hit word. The word holds a radial hit and two azimuthal hits, and each hit carries a position and a deviation. Each azimuthal hit is paired with the radial hit, and a synchronous, writable table looks up every pair. The table returns a transverse-momentum class and a charge for the pair.

Both pairs share the same radial row. The block keeps only the stronger of the two, so only the highest-momentum track survives for that radial position. It emits that track as a registered candidate made of a valid flag, a 3-bit momentum class, a charge bit and a 3-bit sub-sector index.

The table has two read copies, so both pairs are looked up in the same cycle. A plain write port loads the table contents, and writes are expected only while lookups are idle. The unit is fully pipelined and accepts a new hit word on every clock, with no dead time.

Top module: `r_phi_coin`

## Requirements
- R1: Reset is synchronous and active high. While it is asserted, and on the first output cycle after it, `trk_valid`, `trk_pt`, `trk_charge` and `trk_idx` are all zero.
- R2: Layout of `hit_in`:
  - Bit 18 flags a radial hit, bits 17:16 hold the radial row and bits 15:12 hold the radial deviation.
  - Bits 11:6 hold azimuthal hit 1 and bits 5:0 hold azimuthal hit 0. Each takes the form {flag, column, 4-bit deviation}.
  - Both azimuthal hits are looked up in one shared table at the 11-bit address {row, column, radial deviation, azimuthal deviation}.
- R3: The table entry at a given address is {charge, pT[2:0]}. A result appears on the outputs exactly two clocks after its hit word is sampled. A new hit word is accepted on every clock.
- R4: A pair forms a track only under three conditions: the radial hit is flagged, its azimuthal hit is flagged, and the table pT lies in 1..6. A table pT of 0 or 7 means no track.
- R5: When both pairs form tracks, the one with the larger pT is output. On equal pT, azimuthal hit 0 wins.
- R6: `trk_idx` equals row*2 + column of the winning pair.
- R7: With no track, every output field is zero.
- R8: A write through `lut_we`/`lut_waddr`/`lut_wdata` replaces the entry, and later lookups of that address return the new value.
- R9: Whenever `trk_valid` is high, `trk_pt` lies in 1..6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_in | input | 19 | Packed radial and two azimuthal hits |
| lut_we | input | 1 | Table write enable |
| lut_waddr | input | LUT_AW (11) | Table write address |
| lut_wdata | input | 4 | Table entry {charge, pT} |
| trk_valid | output | 1 | Track candidate present |
| trk_pt | output | 3 | Momentum class 1..6, 0 when no track |
| trk_charge | output | 1 | Track charge |
| trk_idx | output | 3 | Sub-sector index row*2+column |

## Verification
On every cycle the assertions check that a valid output has a pT in range and that an idle output is all zeros. They also check that a valid output came from a hit word two clocks earlier that had both a radial hit and at least one azimuthal hit flagged, and that its index carries that word's radial row. Only the bench scenarios can show the values behind those checks:
- the pT and charge actually read from the table;
- the winner chosen on unequal pT and on a tie;
- the rejection of pT codes 0 and 7;
- the effect of a table rewrite.

The bench covers these with back-to-back streamed words and directed cases.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int ROW_W   = 2;
  localparam int COL_W   = 1;
  localparam int DEV_W   = 4;
  localparam int RAD_W   = 1 + ROW_W + DEV_W;
  localparam int PHI_W   = 1 + COL_W + DEV_W;
  localparam int WORD_W  = RAD_W + 2 * PHI_W;
  localparam int ADDR_W  = ROW_W + COL_W + 2 * DEV_W;
  localparam int PT_W    = 3;
  localparam int ENTRY_W = PT_W + 1;
  localparam int IDX_W   = ROW_W + COL_W;
  localparam int N_PHI   = 2;
  localparam logic [PT_W-1:0] PT_TOP = PT_W'(6);

  typedef struct packed {
    logic             v;
    logic [ROW_W-1:0] row;
    logic [DEV_W-1:0] dev;
  } rad_hit_t;

  typedef struct packed {
    logic             v;
    logic [COL_W-1:0] col;
    logic [DEV_W-1:0] dev;
  } phi_hit_t;

  typedef struct packed {
    rad_hit_t rad;
    phi_hit_t phi1;
    phi_hit_t phi0;
  } hit_word_t;

  typedef struct packed {
    logic             v;
    logic [PT_W-1:0]  pt;
    logic             charge;
    logic [IDX_W-1:0] idx;
  } cand_t;
endpackage

// File: rtl/rpc_lut_bank.sv
module rpc_lut_bank #(
  parameter int AW = 11,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rpc_merge.sv
module rpc_merge
  import rpc_pkg::*;
(
  input  logic                          rad_v,
  input  logic [ROW_W-1:0]              row,
  input  logic [N_PHI-1:0]              phi_v,
  input  logic [N_PHI-1:0][COL_W-1:0]   col,
  input  logic [N_PHI-1:0][ENTRY_W-1:0] entry,
  output cand_t                         best
);
  cand_t            cand [N_PHI];
  logic [N_PHI-1:0] ok;

  for (genvar k = 0; k < N_PHI; k++) begin : g_cand
    logic [PT_W-1:0] pt_k;
    assign pt_k = entry[k][PT_W-1:0];
    assign ok[k] = rad_v && phi_v[k] && (pt_k != '0) && (pt_k <= PT_TOP);
    assign cand[k] = '{v: 1'b1, pt: pt_k, charge: entry[k][PT_W],
                       idx: {row, col[k]}};
  end

  always_comb begin
    best = '0;
    if (ok[1] && (!ok[0] || (cand[1].pt > cand[0].pt))) begin
      best = cand[1];
    end else if (ok[0]) begin
      best = cand[0];
    end
  end
endmodule

// File: rtl/r_phi_coin.sv
module r_phi_coin
  import rpc_pkg::*;
#(
  parameter int LUT_AW = ADDR_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [WORD_W-1:0]   hit_in,
  input  logic                lut_we,
  input  logic [LUT_AW-1:0]   lut_waddr,
  input  logic [ENTRY_W-1:0]  lut_wdata,
  output logic                trk_valid,
  output logic [PT_W-1:0]     trk_pt,
  output logic                trk_charge,
  output logic [IDX_W-1:0]    trk_idx
);
  hit_word_t hw;
  phi_hit_t  phis [N_PHI];

  assign hw      = hit_in;
  assign phis[0] = hw.phi0;
  assign phis[1] = hw.phi1;

  // stage 1: table read (registered inside the banks) plus side data
  logic [N_PHI-1:0][ENTRY_W-1:0] s1_entry;
  logic                          s1_rad_v;
  logic [ROW_W-1:0]              s1_row;
  logic [N_PHI-1:0]              s1_phi_v;
  logic [N_PHI-1:0][COL_W-1:0]   s1_col;

  for (genvar k = 0; k < N_PHI; k++) begin : g_bank
    logic [ADDR_W-1:0] full_addr;
    logic [LUT_AW-1:0] raddr;
    assign full_addr = {hw.rad.row, phis[k].col, hw.rad.dev, phis[k].dev};
    assign raddr     = LUT_AW'(full_addr);

    rpc_lut_bank #(.AW(LUT_AW), .DW(ENTRY_W)) bank_i (
      .clk  (clk),
      .we   (lut_we),
      .waddr(lut_waddr),
      .wdata(lut_wdata),
      .raddr(raddr),
      .rdata(s1_entry[k])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_phi_v[k] <= 1'b0;
        s1_col[k]   <= '0;
      end else begin
        s1_phi_v[k] <= phis[k].v;
        s1_col[k]   <= phis[k].col;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_rad_v <= 1'b0;
      s1_row   <= '0;
    end else begin
      s1_rad_v <= hw.rad.v;
      s1_row   <= hw.rad.row;
    end
  end

  // stage 2: pick the stronger pair and register it
  cand_t best, out_q;

  rpc_merge merge_i (
    .rad_v(s1_rad_v),
    .row  (s1_row),
    .phi_v(s1_phi_v),
    .col  (s1_col),
    .entry(s1_entry),
    .best (best)
  );

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= best;
  end

  assign trk_valid  = out_q.v;
  assign trk_pt     = out_q.pt;
  assign trk_charge = out_q.charge;
  assign trk_idx    = out_q.idx;
endmodule

// File: rtl/rpc_checker.sv
module rpc_checker
  import rpc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] hit_in,
  input logic              trk_valid,
  input logic [PT_W-1:0]   trk_pt,
  input logic              trk_charge,
  input logic [IDX_W-1:0]  trk_idx
);
  hit_word_t hw;
  assign hw = hit_in;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!trk_valid && trk_pt == '0 && !trk_charge && trk_idx == '0));

  assert_pt_range_R9: assert property (@(posedge clk) disable iff (rst)
    trk_valid |-> (trk_pt >= PT_W'(1) && trk_pt <= PT_TOP));

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !trk_valid |-> (trk_pt == '0 && !trk_charge && trk_idx == '0));

  assert_needs_radial_R4: assert property (@(posedge clk) disable iff (rst)
    trk_valid |-> $past(hw.rad.v, 2));

  assert_needs_phi_R4: assert property (@(posedge clk) disable iff (rst)
    trk_valid |-> ($past(hw.phi0.v, 2) || $past(hw.phi1.v, 2)));

  assert_row_index_R6: assert property (@(posedge clk) disable iff (rst)
    trk_valid |-> (trk_idx[IDX_W-1:COL_W] == $past(hw.rad.row, 2)));
endmodule

bind r_phi_coin rpc_checker chk_i (
  .clk       (clk),
  .rst       (rst),
  .hit_in    (hit_in),
  .trk_valid (trk_valid),
  .trk_pt    (trk_pt),
  .trk_charge(trk_charge),
  .trk_idx   (trk_idx)
);

// File: tb/r_phi_coin_tb_top.sv
module r_phi_coin_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [18:0] hit_in = '0;
  logic        lut_we = 1'b0;
  logic [10:0] lut_waddr = '0;
  logic [3:0]  lut_wdata = '0;
  logic        trk_valid;
  logic [2:0]  trk_pt;
  logic        trk_charge;
  logic [2:0]  trk_idx;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  r_phi_coin dut_i (
    .clk(clk), .rst(rst), .hit_in(hit_in),
    .lut_we(lut_we), .lut_waddr(lut_waddr), .lut_wdata(lut_wdata),
    .trk_valid(trk_valid), .trk_pt(trk_pt),
    .trk_charge(trk_charge), .trk_idx(trk_idx)
  );

  // word: {rad flag, row, rad dev, phi1 flag, col, dev, phi0 flag, col, dev}
  function automatic logic [18:0] mk(input logic rv, input logic [1:0] row,
      input logic [3:0] rdev, input logic p1v, input logic p1c,
      input logic [3:0] p1d, input logic p0v, input logic p0c,
      input logic [3:0] p0d);
    return {rv, row, rdev, p1v, p1c, p1d, p0v, p0c, p0d};
  endfunction

  // bench table content: charge = radial dev bit 0, pT = azimuthal dev[2:0]
  function automatic logic [3:0] content(input logic [10:0] a);
    return {a[4], a[2:0]};
  endfunction

  // expected {valid, pT, charge, idx}
  localparam int NV = 10;
  localparam logic [26:0] VEC [NV] = '{
    {mk(1, 2, 1, 0, 0, 0,  1, 0, 3),  8'hBC},
    {mk(1, 1, 0, 1, 0, 5,  1, 1, 2),  8'hD2},
    {mk(1, 3, 3, 1, 1, 4,  1, 0, 4),  8'hCE},
    {mk(0, 2, 1, 1, 0, 5,  1, 0, 3),  8'h00},
    {mk(1, 0, 2, 0, 0, 0,  1, 1, 8),  8'h00},
    {mk(1, 0, 1, 1, 1, 1,  1, 0, 7),  8'h99},
    {mk(1, 1, 0, 0, 0, 0,  1, 0, 15), 8'h00},
    {mk(1, 2, 3, 0, 1, 3,  0, 1, 3),  8'h00},
    {mk(1, 3, 0, 1, 0, 14, 1, 1, 6),  8'hE7},
    {mk(1, 2, 2, 1, 1, 3,  0, 0, 5),  8'hB5}
  };

  function automatic logic [7:0] got();
    return {trk_valid, trk_pt, trk_charge, trk_idx};
  endfunction

  task automatic check(input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", got(), 8'h00);
    rst = 1'b0;

    // load the whole table
    for (int a = 0; a < 2048; a++) begin
      @(negedge clk);
      lut_we    = 1'b1;
      lut_waddr = 11'(a);
      lut_wdata = content(11'(a));
    end
    @(negedge clk);
    lut_we = 1'b0;

    // back-to-back stream: check vector k-2 while driving vector k
    for (int k = 0; k < NV + 2; k++) begin
      @(negedge clk);
      if (k >= 2)
        check($sformatf("R3 R4 R5 R6 R7 stream vec %0d", k - 2), got(),
              VEC[k-2][7:0]);
      hit_in = (k < NV) ? VEC[k][26:8] : '0;
    end

    // R8: rewrite one entry, then look it up through each azimuthal input
    @(negedge clk);
    lut_we = 1'b1; lut_waddr = {2'd1, 1'b1, 4'd5, 4'd9}; lut_wdata = 4'b1110;
    @(negedge clk);
    lut_we = 1'b0;
    hit_in = mk(1, 1, 5, 0, 0, 0, 1, 1, 9);
    @(negedge clk);
    hit_in = mk(1, 1, 5, 1, 1, 9, 0, 0, 0);
    @(negedge clk);
    check("R8 rewritten entry via phi0", got(), 8'hEB);
    hit_in = '0;
    @(negedge clk);
    check("R2 shared table via phi1", got(), 8'hEB);
    @(negedge clk);
    check("R7 idle after stream", got(), 8'h00);

    // R1: reset in the middle of traffic
    hit_in = VEC[0][26:8];
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears output", got(), 8'h00);
    rst = 1'b0;
    hit_in = '0;
    @(negedge clk);
    check("R1 first cycle after reset", got(), 8'h00);
    @(negedge clk);
    finish_run();
  end
endmodule